// File: doc/BRIEF.md
# Instruction Byte Queue with Realignment

This block sits between an instruction memory port and the decoder of an 8-bit CPU whose instructions are one, two or three bytes long. It requests aligned 32-bit words and stores their bytes in an eight-slot circular buffer. It shows the decoder a four-byte window that starts at the oldest byte held. An opcode and both of its operand bytes are therefore visible together.

Each cycle the decoder states how long the instruction in the window is. When enough bytes are held, that many bytes leave the queue at the next clock edge. On a redirect the queue empties and the fetch pointer moves to the word that holds the target address. The leading bytes of that word that come before the target are dropped when the word arrives, so the window opens on the target instruction in the following cycle.

Top module: `iq_byte_queue`

## Requirements
- R1: After reset the byte count is 0, the window is not valid, a fetch is requested and the fetch address is 0.
- R2: Window byte i (bits 8i+7:8i) is the byte i positions after the oldest held byte. Consecutive queue bytes have consecutive addresses, and byte k of a fetched word (bits 8k+7:8k) belongs to word address + k.
- R3: The window is valid exactly when the byte count is nonzero and at least the requested length (take_len, encoded 1, 2 or 3).
- R4: When take_en is high and the window is valid, the number of bytes given by take_len leaves the queue at the next edge. When the window is not valid, take_en has no effect.
- R5: A fetch is requested exactly when four or more slots are free (byte count at most 4). The word is accepted at an edge where the request and fetch_ready are both high and no redirect is present.
- R6: Each accepted word advances the fetch address by 4. Fetch addresses always have their low two bits at zero.
- R7: A redirect empties the queue at the next edge and sets the fetch address to the target with its low two bits cleared. Any take and any arriving word in that cycle are ignored.
- R8: The first word accepted after a redirect adds only 4 - t bytes, where t is the low two bits of the target. The window then starts at the target byte.
- R9: The target bytes appear in the window in the cycle after their word is accepted, and not in the acceptance cycle.
- R10: The byte count never exceeds the storage depth of eight.
- R11: While fetch_ready is low, no redirect is present and no take occurs, the byte count and the fetch address hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_valid | input | 1 | Redirect to a new instruction address |
| redir_target | input | ADDR_W | Byte address of the redirect target |
| fetch_req | output | 1 | Request for the word at fetch_addr |
| fetch_addr | output | ADDR_W | Word-aligned fetch byte address |
| fetch_ready | input | 1 | fetch_data holds the requested word this cycle |
| fetch_data | input | 32 | Fetched word, lowest address in bits 7:0 |
| win_bytes | output | 32 | Four-byte window, oldest byte in bits 7:0 |
| win_valid | output | 1 | Window holds at least take_len bytes |
| win_count | output | clog2(DEPTH+1) | Number of bytes held |
| take_en | input | 1 | Decoder consumes the instruction in the window |
| take_len | input | 2 | Instruction length, 1 to 3 |

## Verification
The assertions assume that take_len is 1, 2 or 3 whenever take_en is high. They also assume that fetch_data carries the word for the presented fetch_addr whenever fetch_ready is high. The stimulus draws lengths only from 1 to 3. It builds each delivered word from the model's own fetch pointer, with byte values computed from the address. This lets any misplaced, lost or repeated byte show up in the window. Random redirect targets cover every discard count, and the stall cycles are random. Directed runs force the extreme cases: a three-byte discard, a full queue, a take that is refused, and a redirect that collides with an arriving word.

// File: rtl/iq_pkg.sv
// Shared constants for the instruction byte queue.
// Assumes a byte-addressed instruction space fetched as 32-bit words.
package iq_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int LEN_W      = 2;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/iq_store.sv
// Circular byte store with a four-byte read window.
// Appends a word minus 'push_skip' leading bytes at the tail and
// removes 'pop_len' bytes from the head. Flush empties it.
// Assumes the caller pushes only when four slots are free and pops
// only when at least pop_len bytes are held.
module iq_store
    import iq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push_en,
    input  logic [1:0]                 push_skip,
    input  logic [WORD_W-1:0]          push_word,
    input  logic                       pop_en,
    input  logic [LEN_W-1:0]           pop_len,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [WORD_W-1:0]          window
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    byte_t              slots [DEPTH];
    logic [PTR_W-1:0]   head;
    logic [PTR_W-1:0]   tail;
    logic [PTR_W-1:0]   lane_idx  [WORD_BYTES];
    logic               lane_en   [WORD_BYTES];
    byte_t              lane_byte [WORD_BYTES];
    logic [CNT_W-1:0]   push_n;
    logic [CNT_W-1:0]   pop_n;

    assign tail   = head + count[PTR_W-1:0];
    assign push_n = push_en ? CNT_W'(WORD_BYTES - int'(push_skip)) : '0;
    assign pop_n  = pop_en  ? CNT_W'(pop_len) : '0;

    // One write lane per word byte; lane l takes word byte skip+l.
    for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
        logic [1:0] src;
        assign src          = push_skip + 2'(l);
        assign lane_en[l]   = push_en && (({1'b0, push_skip} + 3'(l)) <= 3'd3);
        assign lane_idx[l]  = tail + PTR_W'(l);
        assign lane_byte[l] = push_word[{src, 3'b000} +: BYTE_W];
    end

    // Window byte w is the byte w places after the head.
    for (genvar w = 0; w < WORD_BYTES; w++) begin : g_win
        assign window[w*BYTE_W +: BYTE_W] = slots[head + PTR_W'(w)];
    end

    // Pointer and count update: flush first, then pop and push together.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head  <= '0;
            count <= '0;
        end else begin
            head  <= head + pop_n[PTR_W-1:0];
            count <= count - pop_n + push_n;
        end
    end

    // Byte storage: write the enabled lanes at the tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) slots[s] <= '0;
        end else if (!flush) begin
            for (int l = 0; l < WORD_BYTES; l++)
                if (lane_en[l]) slots[lane_idx[l]] <= lane_byte[l];
        end
    end
endmodule

// File: rtl/iq_fetch.sv
// Fetch word pointer and post-redirect discard count.
// A redirect loads the target word and keeps the target's byte offset
// as the number of bytes to drop from the next accepted word.
module iq_fetch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redirect_addr,
    input  logic              accept,
    output logic [ADDR_W-1:0] word_addr,
    output logic [1:0]        skip
);
    localparam int WPTR_W = ADDR_W - 2;

    logic [WPTR_W-1:0] wptr;

    assign word_addr = {wptr, 2'b00};

    // Word pointer and skip: redirect reloads, accept steps and clears skip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            skip <= '0;
        end else if (redirect) begin
            wptr <= redirect_addr[ADDR_W-1:2];
            skip <= redirect_addr[1:0];
        end else if (accept) begin
            wptr <= wptr + 1'b1;
            skip <= '0;
        end
    end
endmodule

// File: rtl/iq_byte_queue.sv
// Instruction byte queue: word-wide refill, variable-length drain and
// realignment after a redirect. Requests a word while four slots are
// free. Assumes take_len is 1..3 and fetch_data matches fetch_addr
// when fetch_ready is high.
module iq_byte_queue
    import iq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       redir_valid,
    input  logic [ADDR_W-1:0]          redir_target,
    output logic                       fetch_req,
    output logic [ADDR_W-1:0]          fetch_addr,
    input  logic                       fetch_ready,
    input  logic [WORD_W-1:0]          fetch_data,
    output logic [WORD_W-1:0]          win_bytes,
    output logic                       win_valid,
    output logic [$clog2(DEPTH+1)-1:0] win_count,
    input  logic                       take_en,
    input  logic [LEN_W-1:0]           take_len
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic       accept;
    logic       pop;
    logic [1:0] skip;

    // Request while a whole word fits; accept unless a redirect cancels it.
    assign fetch_req = win_count <= CNT_W'(DEPTH - WORD_BYTES);
    assign accept    = fetch_req && fetch_ready && !redir_valid;

    // Valid when the held bytes cover the stated length.
    assign win_valid = (win_count != '0) && (win_count >= CNT_W'(take_len));
    assign pop       = take_en && win_valid && !redir_valid;

    iq_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .redirect      (redir_valid),
        .redirect_addr (redir_target),
        .accept        (accept),
        .word_addr     (fetch_addr),
        .skip          (skip)
    );

    iq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (redir_valid),
        .push_en   (accept),
        .push_skip (skip),
        .push_word (fetch_data),
        .pop_en    (pop),
        .pop_len   (take_len),
        .count     (win_count),
        .window    (win_bytes)
    );
endmodule

// File: rtl/iq_byte_queue_chk.sv
// Port-level temporal checks for iq_byte_queue, attached by bind.
module iq_byte_queue_chk #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       redir_valid,
    input logic [ADDR_W-1:0]          redir_target,
    input logic                       fetch_req,
    input logic [ADDR_W-1:0]          fetch_addr,
    input logic                       fetch_ready,
    input logic                       win_valid,
    input logic [$clog2(DEPTH+1)-1:0] win_count,
    input logic                       take_en,
    input logic [1:0]                 take_len
);
    localparam int CNT_W = $clog2(DEPTH+1);

    // R10: storage never overfills.
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        win_count <= CNT_W'(DEPTH));

    // R7: a redirect empties the queue.
    a_r7_redirect_empties: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> win_count == '0);

    // R7: a redirect points the fetch at the target's word.
    a_r7_redirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |=> fetch_addr == {$past(redir_target[ADDR_W-1:2]), 2'b00});

    // R6: each accepted word steps the fetch address by four.
    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && fetch_ready && !redir_valid) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

    // R4: a take without refill removes exactly take_len bytes.
    a_r4_pop_len: assert property (@(posedge clk) disable iff (!rst_n)
        (take_en && win_valid && !redir_valid && !(fetch_req && fetch_ready))
        |=> win_count == $past(win_count) - CNT_W'($past(take_len)));

    // R11: with no refill, take or redirect, the state holds.
    a_r11_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_ready && !redir_valid && !(take_en && win_valid))
        |=> ($stable(win_count) && $stable(fetch_addr)));
endmodule

bind iq_byte_queue iq_byte_queue_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .redir_valid  (redir_valid),
    .redir_target (redir_target),
    .fetch_req    (fetch_req),
    .fetch_addr   (fetch_addr),
    .fetch_ready  (fetch_ready),
    .win_valid    (win_valid),
    .win_count    (win_count),
    .take_en      (take_en),
    .take_len     (take_len)
);

// File: tb/tb_iq_byte_queue.sv
// Bench for iq_byte_queue: an address-based model of the queue,
// directed corner cases, then seeded random traffic.
module tb_iq_byte_queue;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam int DEPTH      = 8;
    localparam int CNT_W      = $clog2(DEPTH+1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              redir_valid = 1'b0;
    logic [ADDR_W-1:0] redir_target = '0;
    logic              fetch_req;
    logic [ADDR_W-1:0] fetch_addr;
    logic              fetch_ready = 1'b0;
    logic [31:0]       fetch_data = '0;
    logic [31:0]       win_bytes;
    logic              win_valid;
    logic [CNT_W-1:0]  win_count;
    logic              take_en = 1'b0;
    logic [1:0]        take_len = 2'd1;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Model: queue bytes are consecutive addresses starting at m_head.
    logic [ADDR_W-1:0] m_head = '0;
    int                m_cnt  = 0;
    logic [ADDR_W-3:0] m_fptr = '0;
    logic [1:0]        m_skip = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_byte_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (.*);

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ {a[12:8], 3'b000} ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] mem_word(input logic [ADDR_W-1:0] a);
        return {mem_byte(a + 16'd3), mem_byte(a + 16'd2), mem_byte(a + 16'd1), mem_byte(a)};
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive inputs, check outputs against the model, advance it.
    task automatic step(input logic rv, input logic [ADDR_W-1:0] rt,
                        input logic tk, input logic [1:0] ln, input logic rdy);
        bit pop;
        bit acc;
        redir_valid  = rv;
        redir_target = rt;
        take_en      = tk;
        take_len     = ln;
        fetch_ready  = rdy;
        fetch_data   = mem_word({m_fptr, 2'b00});
        #1;
        check("R4 count", win_count, m_cnt);
        check("R10 bound", win_count <= DEPTH, 1);
        check("R3 valid", win_valid, (m_cnt != 0) && (m_cnt >= ln));
        check("R5 request", fetch_req, m_cnt <= DEPTH - 4);
        check("R6 address", fetch_addr, {m_fptr, 2'b00});
        for (int i = 0; i < 4; i++)
            if (i < m_cnt) check("R2 window", win_bytes[8*i +: 8], mem_byte(m_head + ADDR_W'(i)));
        pop = tk && (m_cnt != 0) && (m_cnt >= ln);
        acc = (m_cnt <= DEPTH - 4) && rdy;
        if (rv) begin
            m_cnt  = 0;
            m_head = rt;
            m_fptr = rt[ADDR_W-1:2];
            m_skip = rt[1:0];
        end else begin
            if (pop) begin
                m_cnt  = m_cnt - ln;
                m_head = m_head + ADDR_W'(ln);
            end
            if (acc) begin
                m_cnt  = m_cnt + 4 - m_skip;
                m_fptr = m_fptr + 1'b1;
                m_skip = '0;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        check("R1 count", win_count, 0);
        check("R1 valid", win_valid, 0);
        check("R1 request", fetch_req, 1);
        check("R1 address", fetch_addr, 0);
        @(negedge clk);

        // R7 and R8: redirect to an offset-3 target while a word arrives.
        step(1'b0, '0, 1'b0, 2'd1, 1'b1);
        step(1'b1, 16'h1233, 1'b1, 2'd1, 1'b1);
        check("R7 empty", win_count, 0);
        check("R7 address", fetch_addr, 16'h1230);
        // R11: stalled refill holds state.
        step(1'b0, '0, 1'b1, 2'd1, 1'b0);
        check("R11 hold count", win_count, 0);
        check("R11 hold address", fetch_addr, 16'h1230);
        // R9: nothing valid in the acceptance cycle.
        check("R9 not yet valid", win_valid, 0);
        step(1'b0, '0, 1'b0, 2'd1, 1'b1);
        check("R8 one byte kept", win_count, 1);
        check("R8 target byte", win_bytes[7:0], mem_byte(16'h1233));
        check("R9 valid next cycle", win_valid, 1);
        // R4: a take longer than the held bytes is refused.
        step(1'b0, '0, 1'b1, 2'd3, 1'b0);
        check("R4 refused take", win_count, 1);
        check("R4 byte kept", win_bytes[7:0], mem_byte(16'h1233));

        // R5: fill to eight, then no further request.
        step(1'b1, 16'h2000, 1'b0, 2'd1, 1'b0);
        step(1'b0, '0, 1'b0, 2'd1, 1'b1);
        step(1'b0, '0, 1'b0, 2'd1, 1'b1);
        check("R5 full count", win_count, 8);
        check("R5 no request when full", fetch_req, 0);
        step(1'b0, '0, 1'b1, 2'd3, 1'b1);
        check("R4 three taken", win_count, 5);
        check("R2 realigned head", win_bytes[7:0], mem_byte(16'h2003));

        // Seeded random traffic.
        for (int c = 0; c < 4000; c++) begin
            logic rv;
            logic [1:0] ln;
            rv = ($urandom_range(0, 99) < 5);
            ln = 2'($urandom_range(1, 3));
            step(rv, 16'($urandom()), ($urandom_range(0, 99) < 70), ln,
                 ($urandom_range(0, 99) < 60));
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule